// File: doc/BRIEF.md
# Thread Yield Qualifier and Release Unit

This block executes one thread-yield request for the thread context that issues it. It receives a 32-bit signed descriptor. Zero asks to release the issuing context. All ones (-1) asks the scheduler to run other threads first, while the issuer stays runnable. The value -2 only polls the qualifier inputs. A positive value is a mask of wait qualifiers. The block sorts the request into one of these modes and applies the legality rules. It then reports one of three things one cycle later: the outcome strobes, a thread exception with a 3-bit cause code, or a reserved-instruction exception.

For a legal positive mask, the issuer is parked. The `blocked` flag stays high until some enabled qualifier input matches a bit of the stored mask. Because the parked state is visible on a port, neighbouring logic can keep reading and writing the parked context's registers. The result value is the qualifier input vector ANDed with the qualifier enable mask. It is delivered when the request completes, and only if the destination register index is nonzero. The release check scans the other contexts' allocatable, halted and active flags and their processor bindings. Scheduling policy itself is left to the consumer of `resched_o`.

Top module: `yq_unit`

## Requirements
- R1: After synchronous reset, every strobe output, `thr_code` and `blocked` are 0.
- R2: A request accepted while `mt_present` is 0 raises `ri_exc` one cycle later and no other strobe.
- R3: A descriptor of 0 completes with `dealloc_o` and `resched_o` one cycle after the request. For this, some context other than `self_tc` must be bound to `self_vpe` with allocatable=1, halted=0 and active=1, and `ysi_en`&`self_dt` must be 0. The result is written when `req_rt_nz` is 1.
- R4: A descriptor of 0 that fails R3 raises `thr_exc` with cause 3'b000 and no release. This includes the case where the only eligible peer is on another processor or is the issuer itself, and the case where `ysi_en`&`self_dt` is set.
- R5: A descriptor of -1 gives `resched_o` plus the result. If `ysi_en`&`self_dt` is set, it instead raises `thr_exc` with cause 3'b100, with no reschedule and no result.
- R6: A descriptor of -2 produces only the result. It never reschedules and never raises the cause 3'b100, even with `ysi_en`&`self_dt` set.
- R7: A positive descriptor with any set bit outside `qual_mask` raises `thr_exc` with cause 3'b010. Bits at or above NQ count as outside. This check takes precedence over the cause 3'b100 check.
- R8: A legal positive descriptor with `ysi_en`&`self_dt` clear raises `blocked` and pulses `resched_o` one cycle later. `blocked` holds until an edge at which `qual_in & qual_mask & mask` is nonzero; one cycle after that edge, `blocked` falls. With `ysi_en`&`self_dt` set, the request raises cause 3'b100 and does not block.
- R9: Descriptor bits 15..10 are ignored in positive mode, for both the legality check and the wait mask.
- R10: `res_valid` pulses only when the request completes without exception and `req_rt_nz` is 1. `res_data` is `qual_in & qual_mask` zero-extended to 32 bits.
- R11: Any negative descriptor other than -1 and -2 raises `ri_exc`.
- R12: A request presented while `blocked` is 1 is ignored and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | yield request strobe |
| req_rs | input | 32 | signed descriptor |
| req_rt_nz | input | 1 | destination register index is nonzero |
| mt_present | input | 1 | multithreading feature implemented |
| ysi_en | input | 1 | yield-scheduler interrupt enable |
| self_dt | input | 1 | issuer's scheduler-trap bit |
| qual_mask | input | NQ | qualifier enable mask |
| qual_in | input | NQ | external qualifier inputs |
| self_tc | input | TW | index of issuing context |
| self_vpe | input | VW | processor of issuing context |
| tc_da | input | NTC | per-context allocatable flags |
| tc_halt | input | NTC | per-context halted flags |
| tc_act | input | NTC | per-context active flags |
| tc_vpe | input | NTC*VW | per-context processor binding, context t at [t*VW +: VW] |
| blocked | output | 1 | issuer parked on qualifiers |
| dealloc_o | output | 1 | release issuer's context |
| resched_o | output | 1 | invoke scheduler |
| res_valid | output | 1 | result write strobe |
| res_data | output | 32 | result value |
| thr_exc | output | 1 | thread exception strobe |
| thr_code | output | 3 | thread exception cause |
| ri_exc | output | 1 | reserved-instruction exception strobe |

## Verification
Each descriptor mode is tried with the scheduler trap both off and on. This separates the modes that invoke the scheduler from the poll mode, which does not. The release mode is run against peer sets that differ in one field at a time: a peer on another processor, a halted peer, an inactive peer and the issuer alone. A failing scan of any one field therefore shows up. Positive masks are run with out-of-range bits, with ignored bits 15..10, and with qualifier inputs that first miss and then hit, which pins down the exact cycles in which the block parks and releases.

// File: rtl/yq_pkg.sv
package yq_pkg;

    localparam int unsigned RS_W = 32;
    localparam logic [RS_W-1:0] IGNORE_BITS = 32'h0000_FC00;  // bits 15..10
    localparam logic [RS_W-1:0] RS_RESCHED  = 32'hFFFF_FFFF;
    localparam logic [RS_W-1:0] RS_POLL     = 32'hFFFF_FFFE;

    typedef enum logic [2:0] {
        M_FREE,
        M_RESCHED,
        M_POLL,
        M_WAIT,
        M_BADNEG
    } yq_mode_e;

    typedef enum logic [2:0] {
        XC_UNDERFLOW = 3'd0,
        XC_BADQUAL   = 3'd2,
        XC_YSCHED    = 3'd4
    } yq_xcode_e;

    typedef struct packed {
        logic      dealloc;
        logic      resched;
        logic      wr;
        logic      thr;
        logic      ri;
        logic      wait_go;
        yq_xcode_e code;
    } yq_act_t;

    function automatic yq_mode_e classify(input logic [RS_W-1:0] rs);
        if (rs == '0)              return M_FREE;
        else if (rs == RS_RESCHED) return M_RESCHED;
        else if (rs == RS_POLL)    return M_POLL;
        else if (!rs[RS_W-1])      return M_WAIT;
        else                       return M_BADNEG;
    endfunction

    function automatic logic [RS_W-1:0] strip_ignored(input logic [RS_W-1:0] rs);
        return rs & ~IGNORE_BITS;
    endfunction

endpackage

// File: rtl/yq_peer_scan.sv
module yq_peer_scan #(
    parameter int unsigned NTC = 4,
    parameter int unsigned VW  = 2,
    localparam int unsigned TW = (NTC > 1) ? $clog2(NTC) : 1
) (
    input  logic [TW-1:0]     self_tc,
    input  logic [VW-1:0]     self_vpe,
    input  logic [NTC-1:0]    tc_da,
    input  logic [NTC-1:0]    tc_halt,
    input  logic [NTC-1:0]    tc_act,
    input  logic [NTC*VW-1:0] tc_vpe,
    output logic              peer_ok
);
    logic [NTC-1:0] eligible;

    for (genvar t = 0; t < NTC; t++) begin : g_tc
        assign eligible[t] = (TW'(t) != self_tc)
                           && (tc_vpe[t*VW +: VW] == self_vpe)
                           && tc_da[t] && !tc_halt[t] && tc_act[t];
    end

    assign peer_ok = |eligible;
endmodule

// File: rtl/yq_decide.sv
module yq_decide
    import yq_pkg::*;
#(
    parameter int unsigned NQ = 16
) (
    input  logic [RS_W-1:0] rs_eff,
    input  yq_mode_e        mode,
    input  logic [NQ-1:0]   qual_mask,
    input  logic            peer_ok,
    input  logic            ysi_en,
    input  logic            self_dt,
    input  logic            mt_present,
    input  logic            rt_nz,
    output yq_act_t         act
);
    logic            trap;
    logic [RS_W-1:0] mask_ext;

    assign trap     = ysi_en & self_dt;
    assign mask_ext = RS_W'(qual_mask);

    always_comb begin
        act      = '0;
        act.code = XC_UNDERFLOW;
        if (!mt_present) begin
            act.ri = 1'b1;
        end else begin
            unique case (mode)
                M_FREE: begin
                    if (peer_ok && !trap) begin
                        act.dealloc = 1'b1;
                        act.resched = 1'b1;
                        act.wr      = rt_nz;
                    end else begin
                        act.thr  = 1'b1;
                        act.code = XC_UNDERFLOW;
                    end
                end
                M_RESCHED: begin
                    if (trap) begin
                        act.thr  = 1'b1;
                        act.code = XC_YSCHED;
                    end else begin
                        act.resched = 1'b1;
                        act.wr      = rt_nz;
                    end
                end
                M_POLL: act.wr = rt_nz;
                M_WAIT: begin
                    if (|(rs_eff & ~mask_ext)) begin
                        act.thr  = 1'b1;
                        act.code = XC_BADQUAL;
                    end else if (trap) begin
                        act.thr  = 1'b1;
                        act.code = XC_YSCHED;
                    end else begin
                        act.resched = 1'b1;
                        act.wait_go = 1'b1;
                    end
                end
                default: act.ri = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/yq_wait.sv
module yq_wait #(
    parameter int unsigned NQ = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NQ-1:0] start_mask,
    input  logic [NQ-1:0] qual_in,
    input  logic [NQ-1:0] qual_mask,
    output logic          blocked,
    output logic          release_now
);
    logic [NQ-1:0] wait_mask;

    assign release_now = blocked && |(qual_in & qual_mask & wait_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            blocked   <= 1'b0;
            wait_mask <= '0;
        end else if (start && !blocked) begin
            blocked   <= 1'b1;
            wait_mask <= start_mask;
        end else if (release_now) begin
            blocked   <= 1'b0;
        end
    end

    a_r8_hold_until_match: assert property (@(posedge clk) disable iff (rst)
        (blocked && !release_now) |=> blocked);
    a_r8_drop_after_match: assert property (@(posedge clk) disable iff (rst)
        release_now |=> !blocked);
endmodule

// File: rtl/yq_unit.sv
module yq_unit
    import yq_pkg::*;
#(
    parameter int unsigned NQ  = 16,   // qualifier count, at most 31
    parameter int unsigned NTC = 4,
    parameter int unsigned VW  = 2,
    localparam int unsigned TW = (NTC > 1) ? $clog2(NTC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_rs,
    input  logic              req_rt_nz,
    input  logic              mt_present,
    input  logic              ysi_en,
    input  logic              self_dt,
    input  logic [NQ-1:0]     qual_mask,
    input  logic [NQ-1:0]     qual_in,
    input  logic [TW-1:0]     self_tc,
    input  logic [VW-1:0]     self_vpe,
    input  logic [NTC-1:0]    tc_da,
    input  logic [NTC-1:0]    tc_halt,
    input  logic [NTC-1:0]    tc_act,
    input  logic [NTC*VW-1:0] tc_vpe,
    output logic              blocked,
    output logic              dealloc_o,
    output logic              resched_o,
    output logic              res_valid,
    output logic [31:0]       res_data,
    output logic              thr_exc,
    output logic [2:0]        thr_code,
    output logic              ri_exc
);
    logic            peer_ok;
    logic            release_now;
    logic            accept;
    logic            rt_hold;
    logic [RS_W-1:0] rs_eff;
    logic [RS_W-1:0] sample;
    yq_mode_e        mode;
    yq_act_t         act;

    assign mode   = classify(req_rs);
    assign rs_eff = strip_ignored(req_rs);
    assign accept = req_valid && !blocked;
    assign sample = RS_W'(qual_in & qual_mask);

    yq_peer_scan #(.NTC(NTC), .VW(VW)) i_scan (
        .self_tc (self_tc),
        .self_vpe(self_vpe),
        .tc_da   (tc_da),
        .tc_halt (tc_halt),
        .tc_act  (tc_act),
        .tc_vpe  (tc_vpe),
        .peer_ok (peer_ok)
    );

    yq_decide #(.NQ(NQ)) i_decide (
        .rs_eff    (rs_eff),
        .mode      (mode),
        .qual_mask (qual_mask),
        .peer_ok   (peer_ok),
        .ysi_en    (ysi_en),
        .self_dt   (self_dt),
        .mt_present(mt_present),
        .rt_nz     (req_rt_nz),
        .act       (act)
    );

    yq_wait #(.NQ(NQ)) i_wait (
        .clk        (clk),
        .rst        (rst),
        .start      (accept && act.wait_go),
        .start_mask (rs_eff[NQ-1:0]),
        .qual_in    (qual_in),
        .qual_mask  (qual_mask),
        .blocked    (blocked),
        .release_now(release_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dealloc_o <= 1'b0;
            resched_o <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            thr_exc   <= 1'b0;
            thr_code  <= '0;
            ri_exc    <= 1'b0;
            rt_hold   <= 1'b0;
        end else begin
            dealloc_o <= 1'b0;
            resched_o <= 1'b0;
            res_valid <= 1'b0;
            thr_exc   <= 1'b0;
            thr_code  <= '0;
            ri_exc    <= 1'b0;
            if (accept) begin
                dealloc_o <= act.dealloc;
                resched_o <= act.resched;
                res_valid <= act.wr;
                thr_exc   <= act.thr;
                thr_code  <= act.thr ? act.code : 3'd0;
                ri_exc    <= act.ri;
                rt_hold   <= req_rt_nz;
                if (act.wr) res_data <= sample;
            end else if (release_now) begin
                res_valid <= rt_hold;
                if (rt_hold) res_data <= sample;
            end
        end
    end

    a_r3_release_reschedules: assert property (@(posedge clk) disable iff (rst)
        dealloc_o |-> resched_o);
    a_r10_no_result_on_exc: assert property (@(posedge clk) disable iff (rst)
        (thr_exc || ri_exc) |-> !res_valid);
    a_r2_absent_feature: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !blocked && !mt_present) |=> ri_exc);
    a_r12_ignore_when_parked: assert property (@(posedge clk) disable iff (rst)
        (req_valid && blocked) |=> !(dealloc_o || resched_o || thr_exc || ri_exc));
    a_r7_cause_legal: assert property (@(posedge clk) disable iff (rst)
        thr_exc |-> (thr_code == 3'd0 || thr_code == 3'd2 || thr_code == 3'd4));
    a_r8_park_reschedules: assert property (@(posedge clk) disable iff (rst)
        $rose(blocked) |-> resched_o);
    a_r4_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dealloc_o, thr_exc, ri_exc}));
endmodule

// File: tb/test_yq_unit.sv
module test_yq_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_rs;
    logic        req_rt_nz, mt_present, ysi_en, self_dt;
    logic [15:0] qual_mask, qual_in;
    logic [1:0]  self_tc, self_vpe;
    logic [3:0]  tc_da, tc_halt, tc_act;
    logic [7:0]  tc_vpe;
    logic        blocked, dealloc_o, resched_o, res_valid, thr_exc, ri_exc;
    logic [31:0] res_data;
    logic [2:0]  thr_code;
    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    yq_unit i_yq_unit (.*);

    typedef struct packed {
        logic [3:0]  tag;
        logic        mt;
        logic [31:0] rs;
        logic        rtnz, ysi, dt;
        logic [3:0]  da, hl, ac;
        logic [7:0]  vp;
        logic [15:0] qm, qi;
        logic [5:0]  ef;   // dealloc,resched,res,thr,ri,blocked
        logic [2:0]  ec;
        logic [15:0] ed;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{4'd2, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 4'h2, 4'h0, 4'h3, 8'h00, 16'hFFFF, 16'h0001, 6'b000010, 3'd0, 16'h0},      // R2
        '{4'd2, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 8'h00, 16'hFFFF, 16'h0001, 6'b000010, 3'd0, 16'h0}, // R2
        '{4'd3, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 4'h2, 4'h0, 4'h3, 8'h00, 16'h00FF, 16'h0F0F, 6'b111000, 3'd0, 16'h000F},    // R3
        '{4'd3, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 4'h8, 4'h0, 4'h8, 8'h04, 16'h00FF, 16'h0F0F, 6'b110000, 3'd0, 16'h0},       // R3 rt zero
        '{4'd4, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 4'h1, 4'h0, 4'h1, 8'h00, 16'hFFFF, 16'h0001, 6'b000100, 3'd0, 16'h0},       // R4 self only
        '{4'd4, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 4'h2, 4'h0, 4'h3, 8'h04, 16'hFFFF, 16'h0001, 6'b000100, 3'd0, 16'h0},       // R4 other vpe
        '{4'd4, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 4'h2, 4'h2, 4'h3, 8'h00, 16'hFFFF, 16'h0001, 6'b000100, 3'd0, 16'h0},       // R4 halted
        '{4'd4, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 4'h2, 4'h0, 4'h1, 8'h00, 16'hFFFF, 16'h0001, 6'b000100, 3'd0, 16'h0},       // R4 inactive
        '{4'd4, 1'b1, 32'h0, 1'b1, 1'b1, 1'b1, 4'h2, 4'h0, 4'h3, 8'h00, 16'hFFFF, 16'h0001, 6'b000100, 3'd0, 16'h0},       // R4 trap
        '{4'd5, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 8'h00, 16'h00F0, 16'h00FF, 6'b011000, 3'd0, 16'h00F0}, // R5
        '{4'd5, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 4'h0, 8'h00, 16'h00F0, 16'h00FF, 6'b000100, 3'd4, 16'h0},    // R5 trap
        '{4'd6, 1'b1, 32'hFFFFFFFE, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 4'h0, 8'h00, 16'hFFFF, 16'h1234, 6'b001000, 3'd0, 16'h1234}, // R6
        '{4'd10, 1'b1, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 8'h00, 16'hFFFF, 16'h1234, 6'b000000, 3'd0, 16'h0},  // R10
        '{4'd7, 1'b1, 32'h3, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 8'h00, 16'h0001, 16'h0001, 6'b000100, 3'd2, 16'h0},        // R7
        '{4'd7, 1'b1, 32'h00010000, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 8'h00, 16'hFFFF, 16'h0001, 6'b000100, 3'd2, 16'h0}, // R7 beyond NQ
        '{4'd7, 1'b1, 32'h3, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 4'h0, 8'h00, 16'h0001, 16'h0001, 6'b000100, 3'd2, 16'h0},        // R7 precedence
        '{4'd11, 1'b1, 32'hFFFFFFFD, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 8'h00, 16'hFFFF, 16'h0001, 6'b000010, 3'd0, 16'h0}, // R11
        '{4'd11, 1'b1, 32'h80000000, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 8'h00, 16'hFFFF, 16'h0001, 6'b000010, 3'd0, 16'h0}, // R11
        '{4'd8, 1'b1, 32'h3, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 4'h0, 8'h00, 16'h0003, 16'h0000, 6'b000100, 3'd4, 16'h0},        // R8 trap
        '{4'd9, 1'b1, 32'h0000FC01, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 4'h0, 8'h00, 16'h0001, 16'h0000, 6'b000100, 3'd4, 16'h0}  // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] flags();
        return {23'd0, thr_code, dealloc_o, resched_o, res_valid, thr_exc, ri_exc, blocked};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_rs = '0; req_rt_nz = 1'b0;
        mt_present = 1'b1; ysi_en = 1'b0; self_dt = 1'b0;
        qual_mask = '0; qual_in = '0; self_tc = 2'd0; self_vpe = 2'd0;
        tc_da = '0; tc_halt = '0; tc_act = '0; tc_vpe = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset", flags(), 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mt_present = TBL[i].mt; req_rs = TBL[i].rs; req_rt_nz = TBL[i].rtnz;
            ysi_en = TBL[i].ysi; self_dt = TBL[i].dt;
            tc_da = TBL[i].da; tc_halt = TBL[i].hl; tc_act = TBL[i].ac; tc_vpe = TBL[i].vp;
            qual_mask = TBL[i].qm; qual_in = TBL[i].qi; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R%0d row %0d flags", TBL[i].tag, i), flags(),
                  {23'd0, TBL[i].ec, TBL[i].ef});
            if (TBL[i].ef[3])
                check($sformatf("R%0d row %0d data", TBL[i].tag, i), res_data, {16'd0, TBL[i].ed});
        end

        // R8: park, miss, R12 ignored request, then hit
        @(negedge clk);
        mt_present = 1'b1; ysi_en = 1'b0; self_dt = 1'b0;
        req_rs = 32'h5; req_rt_nz = 1'b1; qual_mask = 16'h0005; qual_in = 16'h0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 park", flags(), {23'd0, 3'd0, 6'b010001});
        qual_in = 16'h0002;
        repeat (3) @(negedge clk);
        check("R8 miss keeps parked", flags(), {23'd0, 3'd0, 6'b000001});
        req_rs = 32'hFFFFFFFF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 request while parked", flags(), {23'd0, 3'd0, 6'b000001});
        qual_in = 16'h0006;
        @(negedge clk);
        check("R8 release", flags(), {23'd0, 3'd0, 6'b001000});
        check("R10 release data", res_data, 32'h0000_0004);
        @(negedge clk);
        check("R8 settled", flags(), 32'h0);

        // R9: ignored bits do not make a positive mask illegal
        qual_in = 16'h0; qual_mask = 16'h0001; req_rs = 32'h0000_0401; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 parks despite bit 10", flags(), {23'd0, 3'd0, 6'b010001});
        qual_in = 16'h0001;
        @(negedge clk);
        check("R9 release data", res_data, 32'h0000_0001);
        check("R9 release flags", flags(), {23'd0, 3'd0, 6'b001000});

        // R1: reset while parked
        qual_in = 16'h0; req_rs = 32'h1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 park again", {31'd0, blocked}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears parked", flags(), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule